// File: doc/BRIEF.md
# BCD Calendar Counter with Century

This block keeps wall-clock time and calendar date as a chain of packed BCD counters. The chain covers seconds, minutes, hours in 24-hour form, day of week, date, month, two-digit year and two-digit century. A single-cycle 1 Hz enable advances the seconds. Each field that rolls over carries into the next one. The length of each month and the leap-year February are handled inside the block, so software never has to correct the date.

A register window outside this block writes all eight fields in one cycle through the parallel load port. It reads the current time back from the packed BCD outputs, which use the same field widths as the register layout. An oscillator-stop input freezes the whole chain. The bus interface and the 1 Hz prescaler belong to neighbouring blocks.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read 00:00:00, day of week 01, date 01, month 01, year 00 and century 00.
- R2: Each tick with the stop input low and no load advances seconds by one. Seconds 59 wraps to 00 and advances minutes. Minutes 59 wraps to 00 and advances hours. Hours 23 wraps to 00 and advances both the day of week and the date.
- R3: Every field counts in packed BCD, with the units digit in bits [3:0] and the tens digit above it. A units digit of 9 becomes 0 and the tens digit increments, so 09 becomes 10 and 39 becomes 40.
- R4: At the hours wrap, the day of week (3 bits) advances by one, and 07 is followed by 01.
- R5: The date wraps to 01 and advances the month after 30 in months 04, 06, 09 and 11, and after 31 in months 01, 03, 05, 07, 08, 10 and 12.
- R6: In month 02 the date wraps after 29 when the BCD year's value is divisible by four (for example 00, 24, 96) and after 28 otherwise (for example 10, 23).
- R7: Month 12 wraps to 01 and advances the year.
- R8: Year 99 wraps to 00 and advances the century. Century 39 wraps to 00.
- R9: While the stop input is 1, ticks have no effect and all fields hold.
- R10: A load pulse replaces all eight fields in the same cycle. It takes priority over a tick in that cycle, and it also works while the stop input is 1.
- R11: Without a tick the fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle 1 Hz advance enable |
| osc_stop_i | input | 1 | 1 freezes the counter |
| load_i | input | 1 | Parallel load strobe |
| ld_sec_i | input | 7 | Seconds to load, BCD |
| ld_min_i | input | 7 | Minutes to load, BCD |
| ld_hour_i | input | 6 | Hours to load, BCD |
| ld_dow_i | input | 3 | Day of week to load, 1..7 |
| ld_date_i | input | 6 | Date to load, BCD |
| ld_month_i | input | 5 | Month to load, BCD |
| ld_year_i | input | 8 | Year to load, BCD |
| ld_cent_i | input | 6 | Century to load, BCD |
| sec_o | output | 7 | Seconds, BCD 00-59 |
| min_o | output | 7 | Minutes, BCD 00-59 |
| hour_o | output | 6 | Hours, BCD 00-23 |
| dow_o | output | 3 | Day of week 1..7 |
| date_o | output | 6 | Date, BCD 01-31 |
| month_o | output | 5 | Month, BCD 01-12 |
| year_o | output | 8 | Year, BCD 00-99 |
| cent_o | output | 6 | Century, BCD 00-39 |

## Verification
A wrong carry or a wrong wrap limit is visible on the outputs on the same tick that crosses the boundary. Examples are a month length off by one, a leap test on the wrong digit, or a missed century carry. Each such fault shows up as a mismatch one cycle after that tick. For this reason every case loads the counter one second before a boundary and applies a single tick, instead of waiting for the boundary to arrive. A broken stop or load priority shows up as a field that moves in the cycle after a tick that should have been blocked.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int SEC_W   = 7;
  localparam int MIN_W   = 7;
  localparam int HOUR_W  = 6;
  localparam int DOW_W   = 3;
  localparam int DATE_W  = 6;
  localparam int MONTH_W = 5;
  localparam int YEAR_W  = 8;
  localparam int CENT_W  = 6;

  localparam logic [DOW_W-1:0] DOW_LAST = 3'd7;

  // packed BCD increment of a two-digit field, no limit check
  function automatic logic [11:0] bcd_inc(input logic [11:0] v, input int w);
    logic [11:0] r;
    r = '0;
    if (v[3:0] >= 4'd9) r = ((v >> 4) + 12'd1) << 4;
    else                r = v + 12'd1;
    return r & ((12'd1 << w) - 12'd1);
  endfunction
endpackage

// File: rtl/cal_bcd_pair.sv
module cal_bcd_pair #(
  parameter int TW = 3,
  localparam int W = TW + 4,
  parameter logic [W-1:0] WRAP_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] max_i,
  output logic [W-1:0] val_o,
  output logic         wrap_o
);
  import cal_pkg::*;

  logic [W-1:0] val_q;
  logic         at_max;
  logic [11:0]  inc_full;

  assign at_max   = (val_q >= max_i);
  assign inc_full = bcd_inc(12'(val_q), W);
  assign wrap_o   = inc_i & at_max;
  assign val_o    = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= WRAP_VAL;
    else if (load_i) val_q <= load_val_i;
    else if (inc_i)  val_q <= at_max ? WRAP_VAL : inc_full[W-1:0];
  end

  a_r2_wrap_to_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && val_q >= max_i) |=> (val_q == WRAP_VAL));

  a_r3_units_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && val_q[3:0] == 4'd9 && val_q < max_i)
      |=> (val_q[3:0] == 4'd0 && val_q[W-1:4] == TW'($past(val_q[W-1:4]) + 1'b1)));
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  logic [MONTH_W-1:0] month_i,
  input  logic [YEAR_W-1:0]  year_i,
  output logic [DATE_W-1:0]  last_date_o
);
  logic leap;
  logic [3:0] yu;

  assign yu = year_i[3:0];
  // value divisible by 4: even tens with units 0/4/8, odd tens with units 2/6
  assign leap = year_i[4] ? (yu == 4'd2 || yu == 4'd6)
                          : (yu == 4'd0 || yu == 4'd4 || yu == 4'd8);

  always_comb begin
    unique case (month_i)
      5'h02:                      last_date_o = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_date_o = 6'h30;
      default:                    last_date_o = 6'h31;
    endcase
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               osc_stop_i,
  input  logic               load_i,
  input  logic [SEC_W-1:0]   ld_sec_i,
  input  logic [MIN_W-1:0]   ld_min_i,
  input  logic [HOUR_W-1:0]  ld_hour_i,
  input  logic [DOW_W-1:0]   ld_dow_i,
  input  logic [DATE_W-1:0]  ld_date_i,
  input  logic [MONTH_W-1:0] ld_month_i,
  input  logic [YEAR_W-1:0]  ld_year_i,
  input  logic [CENT_W-1:0]  ld_cent_i,
  output logic [SEC_W-1:0]   sec_o,
  output logic [MIN_W-1:0]   min_o,
  output logic [HOUR_W-1:0]  hour_o,
  output logic [DOW_W-1:0]   dow_o,
  output logic [DATE_W-1:0]  date_o,
  output logic [MONTH_W-1:0] month_o,
  output logic [YEAR_W-1:0]  year_o,
  output logic [CENT_W-1:0]  cent_o
);
  logic adv;
  logic sec_wrap, min_wrap, hour_wrap, date_wrap, month_wrap, year_wrap, cent_wrap;
  logic [DATE_W-1:0] last_date;
  logic [DOW_W-1:0]  dow_q;

  assign adv = tick_i & ~osc_stop_i & ~load_i;

  cal_bcd_pair #(.TW(SEC_W-4), .WRAP_VAL(7'h00)) u_sec (
    .clk_i, .rst_ni, .inc_i(adv), .load_i, .load_val_i(ld_sec_i),
    .max_i(7'h59), .val_o(sec_o), .wrap_o(sec_wrap));

  cal_bcd_pair #(.TW(MIN_W-4), .WRAP_VAL(7'h00)) u_min (
    .clk_i, .rst_ni, .inc_i(sec_wrap), .load_i, .load_val_i(ld_min_i),
    .max_i(7'h59), .val_o(min_o), .wrap_o(min_wrap));

  cal_bcd_pair #(.TW(HOUR_W-4), .WRAP_VAL(6'h00)) u_hour (
    .clk_i, .rst_ni, .inc_i(min_wrap), .load_i, .load_val_i(ld_hour_i),
    .max_i(6'h23), .val_o(hour_o), .wrap_o(hour_wrap));

  cal_month_len u_mlen (.month_i(month_o), .year_i(year_o), .last_date_o(last_date));

  cal_bcd_pair #(.TW(DATE_W-4), .WRAP_VAL(6'h01)) u_date (
    .clk_i, .rst_ni, .inc_i(hour_wrap), .load_i, .load_val_i(ld_date_i),
    .max_i(last_date), .val_o(date_o), .wrap_o(date_wrap));

  cal_bcd_pair #(.TW(MONTH_W-4), .WRAP_VAL(5'h01)) u_month (
    .clk_i, .rst_ni, .inc_i(date_wrap), .load_i, .load_val_i(ld_month_i),
    .max_i(5'h12), .val_o(month_o), .wrap_o(month_wrap));

  cal_bcd_pair #(.TW(YEAR_W-4), .WRAP_VAL(8'h00)) u_year (
    .clk_i, .rst_ni, .inc_i(month_wrap), .load_i, .load_val_i(ld_year_i),
    .max_i(8'h99), .val_o(year_o), .wrap_o(year_wrap));

  cal_bcd_pair #(.TW(CENT_W-4), .WRAP_VAL(6'h00)) u_cent (
    .clk_i, .rst_ni, .inc_i(year_wrap), .load_i, .load_val_i(ld_cent_i),
    .max_i(6'h39), .val_o(cent_o), .wrap_o(cent_wrap));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        dow_q <= 3'd1;
    else if (load_i)    dow_q <= ld_dow_i;
    else if (hour_wrap) dow_q <= (dow_q >= DOW_LAST || dow_q == '0) ? 3'd1 : dow_q + 3'd1;
  end
  assign dow_o = dow_q;

  a_r9_stop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_stop_i && !load_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
      $stable(dow_o) && $stable(date_o) && $stable(month_o) && $stable(year_o) && $stable(cent_o)));

  a_r10_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sec_o == $past(ld_sec_i) && date_o == $past(ld_date_i) &&
                cent_o == $past(ld_cent_i) && dow_o == $past(ld_dow_i)));

  a_r4_dow_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && sec_o == 7'h59 && min_o == 7'h59 && hour_o == 6'h23 && dow_o == 3'd7)
      |=> (dow_o == 3'd1));

  a_r8_cent_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (month_wrap && year_o == 8'h99 && cent_o != 6'h39) |=> (year_o == 8'h00 && cent_o != 6'h00));
endmodule

// File: tb/bcd_calendar_tb.sv
module bcd_calendar_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, stop = 1'b0, load = 1'b0;
  logic [47:0] ld_vec = '0;
  logic [6:0] sec, mins;
  logic [5:0] hour, date, cent;
  logic [2:0] dow;
  logic [4:0] month;
  logic [7:0] year;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  bcd_calendar u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .osc_stop_i(stop), .load_i(load),
    .ld_sec_i(ld_vec[6:0]), .ld_min_i(ld_vec[13:7]), .ld_hour_i(ld_vec[19:14]),
    .ld_dow_i(ld_vec[22:20]), .ld_date_i(ld_vec[28:23]), .ld_month_i(ld_vec[33:29]),
    .ld_year_i(ld_vec[41:34]), .ld_cent_i(ld_vec[47:42]),
    .sec_o(sec), .min_o(mins), .hour_o(hour), .dow_o(dow), .date_o(date),
    .month_o(month), .year_o(year), .cent_o(cent));

  wire [47:0] now = {cent, year, month, date, dow, hour, mins, sec};

  // {cent,year,month,date,dow,hour,min,sec}: start state, state after one tick, req number
  localparam int N = 21;
  localparam logic [99:0] TBL [N] = '{
    {{6'h20,8'h23,5'h01,6'h15,3'd3,6'h10,7'h20,7'h09},{6'h20,8'h23,5'h01,6'h15,3'd3,6'h10,7'h20,7'h10},4'd3},  // R3
    {{6'h20,8'h23,5'h01,6'h15,3'd3,6'h10,7'h20,7'h59},{6'h20,8'h23,5'h01,6'h15,3'd3,6'h10,7'h21,7'h00},4'd2},  // R2
    {{6'h20,8'h23,5'h01,6'h15,3'd3,6'h10,7'h59,7'h59},{6'h20,8'h23,5'h01,6'h15,3'd3,6'h11,7'h00,7'h00},4'd2},  // R2
    {{6'h20,8'h23,5'h01,6'h15,3'd3,6'h23,7'h59,7'h59},{6'h20,8'h23,5'h01,6'h16,3'd4,6'h00,7'h00,7'h00},4'd2},  // R2
    {{6'h20,8'h23,5'h01,6'h15,3'd7,6'h23,7'h59,7'h59},{6'h20,8'h23,5'h01,6'h16,3'd1,6'h00,7'h00,7'h00},4'd4},  // R4
    {{6'h20,8'h23,5'h04,6'h30,3'd2,6'h23,7'h59,7'h59},{6'h20,8'h23,5'h05,6'h01,3'd3,6'h00,7'h00,7'h00},4'd5},  // R5
    {{6'h20,8'h23,5'h01,6'h30,3'd2,6'h23,7'h59,7'h59},{6'h20,8'h23,5'h01,6'h31,3'd3,6'h00,7'h00,7'h00},4'd5},  // R5
    {{6'h20,8'h23,5'h11,6'h30,3'd5,6'h23,7'h59,7'h59},{6'h20,8'h23,5'h12,6'h01,3'd6,6'h00,7'h00,7'h00},4'd5},  // R5
    {{6'h20,8'h23,5'h06,6'h30,3'd5,6'h23,7'h59,7'h59},{6'h20,8'h23,5'h07,6'h01,3'd6,6'h00,7'h00,7'h00},4'd5},  // R5
    {{6'h20,8'h23,5'h09,6'h30,3'd6,6'h23,7'h59,7'h59},{6'h20,8'h23,5'h10,6'h01,3'd7,6'h00,7'h00,7'h00},4'd5},  // R5
    {{6'h20,8'h23,5'h08,6'h31,3'd4,6'h23,7'h59,7'h59},{6'h20,8'h23,5'h09,6'h01,3'd5,6'h00,7'h00,7'h00},4'd5},  // R5
    {{6'h20,8'h23,5'h02,6'h28,3'd1,6'h23,7'h59,7'h59},{6'h20,8'h23,5'h03,6'h01,3'd2,6'h00,7'h00,7'h00},4'd6},  // R6
    {{6'h20,8'h24,5'h02,6'h28,3'd1,6'h23,7'h59,7'h59},{6'h20,8'h24,5'h02,6'h29,3'd2,6'h00,7'h00,7'h00},4'd6},  // R6
    {{6'h20,8'h24,5'h02,6'h29,3'd2,6'h23,7'h59,7'h59},{6'h20,8'h24,5'h03,6'h01,3'd3,6'h00,7'h00,7'h00},4'd6},  // R6
    {{6'h20,8'h00,5'h02,6'h28,3'd4,6'h23,7'h59,7'h59},{6'h20,8'h00,5'h02,6'h29,3'd5,6'h00,7'h00,7'h00},4'd6},  // R6
    {{6'h20,8'h10,5'h02,6'h28,3'd4,6'h23,7'h59,7'h59},{6'h20,8'h10,5'h03,6'h01,3'd5,6'h00,7'h00,7'h00},4'd6},  // R6
    {{6'h20,8'h96,5'h02,6'h28,3'd6,6'h23,7'h59,7'h59},{6'h20,8'h96,5'h02,6'h29,3'd7,6'h00,7'h00,7'h00},4'd6},  // R6
    {{6'h20,8'h23,5'h12,6'h31,3'd7,6'h23,7'h59,7'h59},{6'h20,8'h24,5'h01,6'h01,3'd1,6'h00,7'h00,7'h00},4'd7},  // R7
    {{6'h20,8'h99,5'h12,6'h31,3'd5,6'h23,7'h59,7'h59},{6'h21,8'h00,5'h01,6'h01,3'd6,6'h00,7'h00,7'h00},4'd8},  // R8
    {{6'h39,8'h99,5'h12,6'h31,3'd5,6'h23,7'h59,7'h59},{6'h00,8'h00,5'h01,6'h01,3'd6,6'h00,7'h00,7'h00},4'd8},  // R8
    {{6'h20,8'h23,5'h01,6'h15,3'd3,6'h09,7'h59,7'h59},{6'h20,8'h23,5'h01,6'h15,3'd3,6'h10,7'h00,7'h00},4'd3}   // R3
  };

  task automatic check(input logic [47:0] exp, input int req, input string what);
    checks++;
    if (now !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, now, exp);
    end
  endtask

  task automatic do_load(input logic [47:0] v, input logic with_tick);
    @(negedge clk);
    ld_vec = v; load = 1'b1; tick = with_tick;
    @(negedge clk);
    load = 1'b0; tick = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  localparam logic [47:0] V_A = {6'h20,8'h23,5'h06,6'h15,3'd2,6'h12,7'h34,7'h56};
  localparam logic [47:0] V_A1 = {6'h20,8'h23,5'h06,6'h15,3'd2,6'h12,7'h34,7'h57};
  localparam logic [47:0] V_B = {6'h19,8'h88,5'h07,6'h04,3'd5,6'h08,7'h15,7'h30};

  initial begin
    repeat (3) @(negedge clk);
    check({6'h00,8'h00,5'h01,6'h01,3'd1,6'h00,7'h00,7'h00}, 1, "reset state");  // R1
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin
      do_load(TBL[i][99:52], 1'b0);
      check(TBL[i][99:52], 10, "load all fields");                              // R10
      do_tick();
      check(TBL[i][51:4], int'(TBL[i][3:0]), $sformatf("vector %0d", i));
    end
    // R11: no tick, fields hold
    do_load(V_A, 1'b0);
    repeat (5) @(negedge clk);
    check(V_A, 11, "hold without tick");
    // R9: stop blocks ticks
    @(negedge clk); stop = 1'b1;
    repeat (3) do_tick();
    check(V_A, 9, "stop holds");
    // R10: load works while stopped
    do_load(V_B, 1'b0);
    check(V_B, 10, "load while stopped");
    @(negedge clk); stop = 1'b0;
    // R10: load beats simultaneous tick
    do_load(V_A, 1'b1);
    check(V_A, 10, "load over tick");
    // R2: resume after stop released
    do_tick();
    check(V_A1, 2, "tick after stop release");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule